// File: doc/BRIEF.md
# H4 Byte-Stream Packet Deframer

This block sits behind a UART receiver and cuts the incoming byte stream into whole host-transport packets of the H4 kind. Every packet opens with a one-byte type code. A header follows, and its size depends on the type. A payload then follows, and its size is read from the header as the bytes arrive. The block works out how many bytes it still needs while the packet is coming in. This covers the two vendor types, where the header size is carried inside the packet or fixed by the type, and one vendor command opcode whose payload is one byte longer than declared, rounded down to an even count. Each byte is written into a local packet buffer at its offset within the packet.

When the last byte of a packet has been taken, a one-cycle done strobe appears together with the type code and the total byte count, type byte included. The buffer can then be read through a synchronous read port. An unknown type code, or a packet that declares more bytes than the buffer holds, produces a one-cycle error strobe. The block then drops the packet and treats the next byte as a new type code. Bytes offered while the enable is low are ignored.

The controller has three states. LEAD collects the type byte and the byte after it. HDR collects the rest of the header. PAY collects the payload. The transitions are as follows. LEAD→LEAD happens on an accepted type byte, on an unknown-type error, or when a two-byte packet completes. LEAD→HDR happens on the second byte when the header is longer than two bytes. HDR→LEAD happens when the header is complete and there is no payload, or when the declared total is too large. HDR→PAY happens when the header is complete and a payload is declared. PAY→LEAD happens on the last payload byte.

Top module: `h4_rx_deframer`

## Requirements
- R1: Type codes 1 (command), 2 (ACL data), 3 (SCO data), 4 (event), 6 (negotiation) and 7 (keep-alive) are accepted. Any other value taken as a first byte raises `pkt_err` for one cycle. The next accepted byte is treated as a new type code.
- R2: Headers, counting the type byte, are 4 bytes for command, 3 for event, 5 for ACL and 4 for SCO. The payload length is byte 3 for command, byte 2 for event and byte 3 for SCO, where byte 0 is the type.
- R3: For a negotiation packet the total length is byte 1 plus 2. A keep-alive packet is always 4 bytes. Neither type has a payload, and a negotiation packet with byte 1 equal to 0 completes on its second byte.
- R4: A command whose opcode (byte 1 low, byte 2 high) is 0xFC00 has a payload of (byte 3 + 1) rounded down to even. Every other command uses byte 3 unchanged.
- R5: The ACL payload length is the 16-bit value with byte 3 as the low half and byte 4 as the high half.
- R6: If the header implies a total above `BUF_BYTES`, `pkt_err` pulses in the cycle after the last header byte is taken. The block then resynchronises at the next byte. A total equal to `BUF_BYTES` is accepted.
- R7: A byte is taken only when `en` and `in_vld` are both high. Otherwise it has no effect on state, buffer or strobes.
- R8: `pkt_done` is high for exactly the one cycle after the clock edge that takes a packet's last byte. In that cycle `pkt_type` and `pkt_len` (the total including the type byte) are valid. `pkt_done` and `pkt_err` are never high together.
- R9: Byte i of the packet just completed is returned on `rd_data` one cycle after `rd_addr` = i is presented. It stays readable until the next packet's bytes overwrite it.
- R10: After reset `pkt_done`, `pkt_err`, `pkt_type` and `pkt_len` are 0, and the next accepted byte is taken as a type code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receive enable; bytes are ignored while low |
| in_vld | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte |
| rd_addr | input | AW ($clog2(BUF_BYTES)) | Buffer read offset |
| rd_data | output | 8 | Buffer byte at the previous cycle's `rd_addr` |
| pkt_type | output | 8 | Type code of the last completed or rejected packet |
| pkt_len | output | LW ($clog2(BUF_BYTES+1)) | Total length of the last completed packet |
| pkt_done | output | 1 | One-cycle packet-complete strobe |
| pkt_err | output | 1 | One-cycle error strobe (unknown type or oversize) |

## Verification
The cases that are hardest to reach from the ports are the length-limit edges. One ACL packet must declare exactly `BUF_BYTES` bytes, and another must declare one byte more. Together they expose off-by-one errors in the limit compare and in the 16-bit assembly of the length field. The stimulus streams a full 4096-byte packet and then reads its first and last buffer bytes. The oversize header is sent immediately before a keep-alive packet, so the resynchronisation is tested on the very next byte. The enable gate is tested by holding bytes off in the middle of an event header and checking that the later length decode and buffer offsets still line up.

// File: rtl/h4_pkg.sv
package h4_pkg;

    localparam logic [7:0] TYP_CMD   = 8'd1;
    localparam logic [7:0] TYP_ACL   = 8'd2;
    localparam logic [7:0] TYP_SCO   = 8'd3;
    localparam logic [7:0] TYP_EVT   = 8'd4;
    localparam logic [7:0] TYP_NEG   = 8'd6;
    localparam logic [7:0] TYP_ALIVE = 8'd7;

    // Header sizes counting the type byte
    localparam logic [8:0] HDR_CMD   = 9'd4;
    localparam logic [8:0] HDR_EVT   = 9'd3;
    localparam logic [8:0] HDR_ACL   = 9'd5;
    localparam logic [8:0] HDR_SCO   = 9'd4;
    localparam logic [8:0] HDR_ALIVE = 9'd4;

    localparam logic [15:0] VENDOR_OPC = 16'hFC00;

    // Number of header bytes after the type byte kept in flops
    localparam int HB_N = 4;

    // Width of the header+payload total before the limit check
    localparam int TOT_W = 17;

    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_HDR  = 2'd1,
        PH_PAY  = 2'd2
    } phase_t;

endpackage

// File: rtl/h4_len_calc.sv
module h4_len_calc
    import h4_pkg::*;
(
    input  logic [7:0]  typ,
    input  logic [7:0]  b1,
    input  logic [7:0]  b2,
    input  logic [7:0]  b3,
    input  logic [7:0]  b4,
    output logic        type_ok,
    output logic [8:0]  hdr_tot,
    output logic [15:0] pay_len
);

    logic [8:0] odd_up;

    always_comb begin
        odd_up  = ({1'b0, b3} + 9'd1) & 9'h1FE;
        type_ok = 1'b1;
        hdr_tot = 9'd0;
        pay_len = 16'd0;
        case (typ)
            TYP_CMD: begin
                hdr_tot = HDR_CMD;
                pay_len = ({b2, b1} == VENDOR_OPC) ? {7'd0, odd_up} : {8'd0, b3};
            end
            TYP_ACL: begin
                hdr_tot = HDR_ACL;
                pay_len = {b4, b3};
            end
            TYP_SCO: begin
                hdr_tot = HDR_SCO;
                pay_len = {8'd0, b3};
            end
            TYP_EVT: begin
                hdr_tot = HDR_EVT;
                pay_len = {8'd0, b2};
            end
            TYP_NEG: begin
                hdr_tot = {1'b0, b1} + 9'd2;
            end
            TYP_ALIVE: begin
                hdr_tot = HDR_ALIVE;
            end
            default: begin
                type_ok = 1'b0;
            end
        endcase
    end

    // Every known type declares a header of at least two bytes
    always_comb begin
        if (type_ok) begin
            a_r3_hdr_min: assert (hdr_tot >= 9'd2);
        end
    end

endmodule

// File: rtl/h4_pkt_buf.sv
module h4_pkt_buf #(
    parameter  int DEPTH = 4096,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/h4_rx_deframer.sv
module h4_rx_deframer
    import h4_pkg::*;
#(
    parameter  int BUF_BYTES = 4096,
    localparam int AW        = $clog2(BUF_BYTES),
    localparam int LW        = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_vld,
    input  logic [7:0]    in_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [7:0]    pkt_type,
    output logic [LW-1:0] pkt_len,
    output logic          pkt_done,
    output logic          pkt_err
);

    localparam logic [LW-1:0]    NEED_LEAD = LW'(2);
    localparam logic [TOT_W-1:0] LIMIT     = TOT_W'(BUF_BYTES);

    phase_t        st_q, st_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] need_q, need_d;
    logic [7:0]    typ_q;
    logic [7:0]    hb_q [1:HB_N];
    logic [7:0]    hb_v [1:HB_N];
    logic [7:0]    cur_typ;
    logic          take;

    logic          type_ok;
    logic [8:0]    hdr_tot;
    logic [15:0]   pay_len;
    logic [TOT_W-1:0] tot;

    logic          hdr_end;
    logic          fin_ok, fin_bad;
    logic [LW-1:0] fin_len;

    assign take    = en & in_vld;
    assign cur_typ = (cnt_q == '0) ? in_byte : typ_q;

    // Header byte views: the byte arriving now overrides its stored copy
    for (genvar gi = 1; gi <= HB_N; gi++) begin : g_hb
        assign hb_v[gi] = (cnt_q == LW'(gi)) ? in_byte : hb_q[gi];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hb_q[gi] <= 8'd0;
            end else if (take && cnt_q == LW'(gi)) begin
                hb_q[gi] <= in_byte;
            end
        end
    end

    h4_len_calc u_len (
        .typ     (cur_typ),
        .b1      (hb_v[1]),
        .b2      (hb_v[2]),
        .b3      (hb_v[3]),
        .b4      (hb_v[4]),
        .type_ok (type_ok),
        .hdr_tot (hdr_tot),
        .pay_len (pay_len)
    );

    h4_pkt_buf #(.DEPTH(BUF_BYTES)) u_buf (
        .clk   (clk),
        .we    (take),
        .waddr (cnt_q[AW-1:0]),
        .wdata (in_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign tot = TOT_W'(hdr_tot) + TOT_W'(pay_len);

    // Next-state logic
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        need_d  = need_q;
        hdr_end = 1'b0;
        fin_ok  = 1'b0;
        fin_bad = 1'b0;
        fin_len = '0;
        if (take) begin
            cnt_d = cnt_q + LW'(1);
            unique case (st_q)
                PH_LEAD: begin
                    if (cnt_q == '0) begin
                        fin_bad = ~type_ok;
                    end else if (hdr_tot > 9'd2) begin
                        st_d   = PH_HDR;
                        need_d = LW'(hdr_tot);
                    end else begin
                        hdr_end = 1'b1;
                    end
                end
                PH_HDR: begin
                    hdr_end = (cnt_d == need_q);
                end
                PH_PAY: begin
                    if (cnt_d == need_q) begin
                        fin_ok  = 1'b1;
                        fin_len = need_q;
                    end
                end
                default: begin
                    fin_bad = 1'b1;
                end
            endcase
            if (hdr_end) begin
                if (tot > LIMIT) begin
                    fin_bad = 1'b1;
                end else if (pay_len == 16'd0) begin
                    fin_ok  = 1'b1;
                    fin_len = LW'(tot);
                end else begin
                    st_d   = PH_PAY;
                    need_d = LW'(tot);
                end
            end
            if (fin_ok || fin_bad) begin
                st_d   = PH_LEAD;
                cnt_d  = '0;
                need_d = NEED_LEAD;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH_LEAD;
            cnt_q  <= '0;
            need_q <= NEED_LEAD;
            typ_q  <= 8'd0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            need_q <= need_d;
            if (take && cnt_q == '0) begin
                typ_q <= in_byte;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_done <= 1'b0;
            pkt_err  <= 1'b0;
            pkt_type <= 8'd0;
            pkt_len  <= '0;
        end else begin
            pkt_done <= fin_ok;
            pkt_err  <= fin_bad;
            if (fin_ok || fin_bad) begin
                pkt_type <= cur_typ;
            end
            if (fin_ok) begin
                pkt_len <= fin_len;
            end
        end
    end

    a_r1_unknown_type_err: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cnt_q == '0 && !type_ok) |=> (pkt_err && cnt_q == '0));

    a_r7_idle_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && in_vld) |=> (!pkt_done && !pkt_err && $stable(cnt_q) && $stable(st_q)));

    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done && pkt_err));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    a_r6_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len >= LW'(2) && pkt_len <= LW'(BUF_BYTES)));

    a_r1_resync_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done || pkt_err) |-> (cnt_q == '0 && st_q == PH_LEAD));

    a_r6_need_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_PAY) |-> (need_q <= LW'(BUF_BYTES) && cnt_q < need_q));

endmodule

// File: tb/h4_rx_deframer_tb_top.sv
module h4_rx_deframer_tb_top;

    localparam int BUF = 4096;
    localparam int AW  = $clog2(BUF);
    localparam int LW  = $clog2(BUF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          in_vld = 1'b0;
    logic [7:0]    in_byte = 8'd0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [7:0]    pkt_type;
    logic [LW-1:0] pkt_len;
    logic          pkt_done;
    logic          pkt_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_req = "R10";

    logic [7:0] q[$];
    logic [7:0] last_pkt[$];

    always #4 clk = ~clk;

    h4_rx_deframer #(.BUF_BYTES(BUF)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_vld   (in_vld),
        .in_byte  (in_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pkt_type (pkt_type),
        .pkt_len  (pkt_len),
        .pkt_done (pkt_done),
        .pkt_err  (pkt_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit known(input logic [7:0] t);
        return t inside {8'd1, 8'd2, 8'd3, 8'd4, 8'd6, 8'd7};
    endfunction

    function automatic int hdr_of();
        case (q[0])
            8'd1: return 4;
            8'd2: return 5;
            8'd3: return 4;
            8'd4: return 3;
            8'd6: return int'(q[1]) + 2;
            default: return 4;
        endcase
    endfunction

    function automatic int pay_of();
        case (q[0])
            8'd1: return (q[1] == 8'h00 && q[2] == 8'hFC) ? ((int'(q[3]) + 1) & ~1) : int'(q[3]);
            8'd2: return int'(q[3]) + 256 * int'(q[4]);
            8'd3: return int'(q[3]);
            8'd4: return int'(q[2]);
            default: return 0;
        endcase
    endfunction

    // 0: keep collecting, 1: packet complete, 2: error
    function automatic int model();
        int s, h, t;
        s = q.size();
        if (s == 1) return known(q[0]) ? 0 : 2;
        h = hdr_of();
        if (s < h) return 0;
        t = h + pay_of();
        if (s == h && t > BUF) return 2;
        if (s == t) return 1;
        return 0;
    endfunction

    task automatic tick(input logic v, input logic e, input logic [7:0] b, input int ra);
        int res;
        @(negedge clk);
        in_vld  = v;
        en      = e;
        in_byte = b;
        rd_addr = AW'(ra);
        @(posedge clk);
        #2;
        res = 0;
        if (v && e) begin
            q.push_back(b);
            res = model();
        end
        chk(pkt_done == (res == 1), cur_req, "pkt_done", pkt_done, res == 1);
        chk(pkt_err == (res == 2), cur_req, "pkt_err", pkt_err, res == 2);
        if (res == 1) begin
            chk(pkt_len == LW'(q.size()), cur_req, "pkt_len", pkt_len, q.size());
            chk(pkt_type == q[0], cur_req, "pkt_type", pkt_type, q[0]);
            last_pkt = q;
            q.delete();
        end else if (res == 2) begin
            chk(pkt_type == q[0], cur_req, "pkt_type on error", pkt_type, q[0]);
            q.delete();
        end
    endtask

    task automatic send(input logic [7:0] p[$]);
        foreach (p[i]) tick(1'b1, 1'b1, p[i], 0);
    endtask

    task automatic read_at(input int a);
        tick(1'b0, 1'b1, 8'd0, a);
        chk(rd_data == last_pkt[a], "R9", "rd_data", rd_data, last_pkt[a]);
    endtask

    task automatic read_all();
        foreach (last_pkt[i]) read_at(i);
    endtask

    task automatic fill(ref logic [7:0] p[$], input int n, input int seed);
        for (int i = 0; i < n; i++) p.push_back(8'((i * 7 + seed) & 8'hFF));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] p[$];
        repeat (3) @(posedge clk);
        #2;
        // R10: outputs after reset
        chk(pkt_done == 1'b0, "R10", "pkt_done", pkt_done, 0);
        chk(pkt_err == 1'b0, "R10", "pkt_err", pkt_err, 0);
        chk(pkt_len == '0, "R10", "pkt_len", pkt_len, 0);
        chk(pkt_type == 8'd0, "R10", "pkt_type", pkt_type, 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1'b0, 1'b1, 8'd0, 0);

        // R10 and R2: plain command straight after reset
        cur_req = "R2";
        p = {8'h01, 8'h03, 8'h0C, 8'h02, 8'hAA, 8'hBB};
        send(p);
        read_all();

        // R4: vendor command, odd and even length bytes
        cur_req = "R4";
        p = {8'h01, 8'h00, 8'hFC, 8'h05};
        fill(p, 6, 1);
        send(p);
        p = {8'h01, 8'h00, 8'hFC, 8'h04};
        fill(p, 4, 2);
        send(p);
        // R4: same low byte, other high byte keeps length unchanged
        p = {8'h01, 8'h00, 8'hFD, 8'h05};
        fill(p, 5, 3);
        send(p);
        read_all();

        // R2: event with payload and with none, SCO
        cur_req = "R2";
        p = {8'h04, 8'h0E, 8'h03, 8'h11, 8'h22, 8'h33};
        send(p);
        p = {8'h04, 8'h0E, 8'h00};
        send(p);
        p = {8'h03, 8'h01, 8'h00, 8'h02, 8'h5A, 8'hA5};
        send(p);
        read_all();

        // R5: ACL with a length above 255
        cur_req = "R5";
        p = {8'h02, 8'h01, 8'h20, 8'h05, 8'h01};
        fill(p, 261, 9);
        send(p);
        read_at(0);
        read_at(4);
        read_at(265);

        // R3: negotiation lengths and keep-alive
        cur_req = "R3";
        p = {8'h06, 8'h0A};
        fill(p, 10, 4);
        send(p);
        p = {8'h06, 8'h00};
        send(p);
        p = {8'h06, 8'h01, 8'h77};
        send(p);
        p = {8'h07, 8'h00, 8'h55, 8'h00};
        send(p);
        read_all();

        // R1: unknown type codes, then a valid packet
        cur_req = "R1";
        p = {8'h05, 8'h00, 8'hFF, 8'h08};
        send(p);
        p = {8'h07, 8'h01, 8'h02, 8'h03};
        send(p);
        read_all();

        // R7: bytes blocked by en low or in_vld low inside a header
        cur_req = "R7";
        tick(1'b1, 1'b1, 8'h04, 0);
        tick(1'b1, 1'b1, 8'h0F, 0);
        tick(1'b1, 1'b0, 8'h00, 0);
        tick(1'b1, 1'b0, 8'h99, 0);
        tick(1'b0, 1'b1, 8'h00, 0);
        tick(1'b1, 1'b1, 8'h02, 0);
        tick(1'b1, 1'b0, 8'h44, 0);
        tick(1'b1, 1'b1, 8'hC1, 0);
        tick(1'b1, 1'b1, 8'hC2, 0);
        read_all();

        // R6: oversize declaration, then resync on a keep-alive
        cur_req = "R6";
        p = {8'h02, 8'h00, 8'h00, 8'hFC, 8'h0F};
        send(p);
        p = {8'h07, 8'h09, 8'h08, 8'h07};
        send(p);
        read_all();

        // R6: total exactly at the buffer size
        p = {8'h02, 8'h03, 8'h00, 8'hFB, 8'h0F};
        fill(p, BUF - 5, 5);
        send(p);
        read_at(0);
        read_at(3);
        read_at(BUF - 1);

        tick(1'b0, 1'b1, 8'd0, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule